// File: doc/BRIEF.md
# Command Ring Pointer Controller

This block owns the four registers that steer a ring of fixed-size commands kept in memory: a control word, a base word, a producer (write) pointer and a consumer (read) pointer. Software fills command slots in memory and then moves the write pointer forward. While the block is enabled and the two pointers differ, it reads the 32-byte command at the read pointer through a memory read port and offers it to a downstream sink over a valid/ready handshake. After each command it moves the read pointer on by one slot, and the pointer wraps to the start at the end of the ring. What the commands mean is left to the sink.

Register writes carry 64 data bits and eight byte enables, so both 32-bit and 64-bit accesses merge into the stored value lane by lane. A 32-bit access to the upper half places its data in lanes 7..4. `reg_addr` selects the register: 0 selects control, 1 selects base, 2 selects the write pointer and 3 selects the read pointer. Reads are combinational from `reg_addr`.

Top module: `cmdq_ctrl`

## Requirements
- R1: After reset the control word reads 0x8000_0000, and the base, write-pointer and read-pointer registers read 0. No memory request and no command are offered.
- R2: A register write changes only the bytes whose enable bit is set. For example, writing zero to base with enables 0x0F clears only bits 31:0.
- R3: A write to base is ignored while the enable bit (control bit 0) is 1.
- R4: An accepted base write sets the write pointer equal to the read pointer, which leaves the ring empty.
- R5: Base bits 51:48 and 15:12 always read 0. All other base bits keep the written value.
- R6: The pointer registers hold a byte offset in bits 19:5, and all other bits read 0. A write-pointer value whose offset is at or beyond the ring size, which is (base[7:0]+1)<<12 bytes, is ignored.
- R7: Control bit 0 reads back the enable bit, and control bit 31 reads 1 exactly when the read and write pointers are equal.
- R8: Writes to the read-pointer register are ignored. The read pointer moves only when a command completes.
- R9: Only while enabled and with the pointers unequal, the block raises `mem_req` for one command at a time, at address {base[47:12],12'h000} + read pointer. It holds the request until `mem_rvalid`.
- R10: A fetch that completes without error presents the fetched data on `cmd_data` with `cmd_valid`, and holds both until `cmd_ready`. The read pointer then advances by 32.
- R11: A fetch that returns `mem_err` sends no command, but the read pointer still advances by 32.
- R12: When the read pointer would reach the ring size it wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 base, 2 write pointer, 3 read pointer |
| reg_be | input | 8 | Byte enables for the write |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for the selected register |
| mem_req | output | 1 | Command fetch request, held until answered |
| mem_addr | output | 48 | Byte address of the command to fetch |
| mem_rvalid | input | 1 | Fetch response valid |
| mem_err | input | 1 | Fetch response failed |
| mem_rdata | input | CMD_BITS | Fetched command |
| cmd_valid | output | 1 | Command offered to the sink |
| cmd_data | output | CMD_BITS | Command contents |
| cmd_ready | input | 1 | Sink accepts the command |

## Verification
The bench places the write pointer exactly at the ring size and expects the write to be dropped; an off-by-one limit check would instead accept it and then fetch past the end of the ring. It drives the ring through its last slot and back to slot 0. A design that wrapped at the wrong point, or never wrapped, would fetch from the wrong address, and the per-cycle model comparison catches that. It injects a failed fetch and expects the slot to be skipped and the pointer to still move; a design that forwarded the failed command or stalled on it would show the wrong handshake count or leave the ring busy. It also writes base while enabled and while commands are pending: a lock that did not hold would change the base, and a base write that did not clear the ring would leave the stale pointer and a non-quiescent status.

// File: rtl/cmdq_ctrl.sv
`timescale 1ns/1ps
module cmdq_ctrl #(
  parameter int CMD_BITS = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [4:3]          reg_addr,
  input  logic [7:0]          reg_be,
  input  logic [63:0]         reg_wdata,
  output logic [63:0]         reg_rdata,
  output logic                mem_req,
  output logic [47:0]         mem_addr,
  input  logic                mem_rvalid,
  input  logic                mem_err,
  input  logic [CMD_BITS-1:0] mem_rdata,
  output logic                cmd_valid,
  output logic [CMD_BITS-1:0] cmd_data,
  input  logic                cmd_ready
);
  localparam int PTR_W = 15;
  localparam logic [63:0] BASE_KEEP = ~((64'hF << 48) | (64'hF << 12));

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_SEND} state_t;

  state_t            st_q;
  logic              en_q;
  logic [63:0]       base_q;
  logic [PTR_W-1:0]  wr_q, rd_q, rd_nxt, wr_fld;
  logic [PTR_W:0]    ring_slots, rd_inc;
  logic [63:0]       base_mrg;
  logic              step, base_wr, wr_ok;

  assign ring_slots = ({8'd0, base_q[7:0]} + 16'd1) << 7;
  assign step    = (st_q == S_FETCH && mem_rvalid && mem_err) || (st_q == S_SEND && cmd_ready);
  assign rd_inc  = {1'b0, rd_q} + 16'd1;
  assign rd_nxt  = step ? ((rd_inc == ring_slots) ? '0 : rd_inc[PTR_W-1:0]) : rd_q;

  always_comb begin
    for (int b = 0; b < 8; b++)
      base_mrg[8*b +: 8] = reg_be[b] ? reg_wdata[8*b +: 8] : base_q[8*b +: 8];
    for (int i = 0; i < PTR_W; i++)
      wr_fld[i] = reg_be[(i+5)/8] ? reg_wdata[i+5] : wr_q[i];
  end

  assign base_wr = reg_wr && reg_addr == 2'd1 && !en_q;
  assign wr_ok   = reg_wr && reg_addr == 2'd2 && ({1'b0, wr_fld} < ring_slots);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      en_q     <= 1'b0;
      base_q   <= '0;
      wr_q     <= '0;
      rd_q     <= '0;
      cmd_data <= '0;
    end else begin
      rd_q <= rd_nxt;
      if (reg_wr && reg_addr == 2'd0 && reg_be[0]) en_q <= reg_wdata[0];
      if (base_wr) begin
        base_q <= base_mrg & BASE_KEEP;
        wr_q   <= rd_nxt;
      end else if (wr_ok) begin
        wr_q <= wr_fld;
      end
      case (st_q)
        S_IDLE:  if (en_q && rd_q != wr_q) st_q <= S_FETCH;
        S_FETCH: if (mem_rvalid) begin
                   if (mem_err) st_q <= S_IDLE;
                   else begin
                     cmd_data <= mem_rdata;
                     st_q     <= S_SEND;
                   end
                 end
        default: if (cmd_ready) st_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = st_q == S_FETCH;
  assign cmd_valid = st_q == S_SEND;
  assign mem_addr  = {base_q[47:12], 12'd0} + {28'd0, rd_q, 5'd0};

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {32'd0, rd_q == wr_q, 30'd0, en_q};
      2'd1:    reg_rdata = base_q;
      2'd2:    reg_rdata = {44'd0, wr_q, 5'd0};
      default: reg_rdata = {44'd0, rd_q, 5'd0};
    endcase
  end

  a_r3_base_locked: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(base_q));
  a_r4_base_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && reg_rdata[0] == 1'b0 && !en_q) |=> (wr_q == rd_q));
  a_r8_rd_only_by_progress: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_q) |-> $past((mem_req && mem_rvalid && mem_err) || (cmd_valid && cmd_ready)));
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
  a_r9_fetch_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(en_q));
  a_r10_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));
endmodule

// File: tb/test_cmdq_ctrl.sv
`timescale 1ns/1ps
module test_cmdq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_be = 8'd0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_rvalid = 1'b0, mem_err = 1'b0;
  logic [47:0] mem_addr;
  logic [255:0] mem_rdata = '0, cmd_data;
  logic cmd_valid, cmd_ready = 1'b0;

  int n_chk = 0, n_fail = 0, cyc = 0, n_hs = 0, lat = 0, err_slot = -1;

  int m_en, m_wr, m_rd, m_st;
  logic [63:0] m_base;
  logic [255:0] m_data;

  cmdq_ctrl i_cmdq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready));

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      finish_up();
    end
  end

  // reference model, updated on each rising edge
  always @(posedge clk) begin : model
    int sz, nrd, nw;
    bit done;
    logic [63:0] mg;
    if (!rst_n) begin
      m_en = 0; m_wr = 0; m_rd = 0; m_st = 0; m_base = '0; m_data = '0;
    end else begin
      sz = (int'(m_base[7:0]) + 1) * 128;
      done = 0;
      case (m_st)
        0: if (m_en != 0 && m_rd != m_wr) m_st = 1;
        1: if (mem_rvalid) begin
             if (mem_err) begin done = 1; m_st = 0; end
             else begin m_data = mem_rdata; m_st = 2; end
           end
        default: if (cmd_ready) begin done = 1; m_st = 0; end
      endcase
      nrd = m_rd;
      if (done) nrd = (m_rd + 1 == sz) ? 0 : m_rd + 1;
      if (reg_wr) begin
        case (reg_addr)
          2'd0: if (reg_be[0]) m_en = int'(reg_wdata[0]);
          2'd1: if (m_en == 0) begin
                  mg = m_base;
                  for (int b = 0; b < 8; b++) if (reg_be[b]) mg[8*b +: 8] = reg_wdata[8*b +: 8];
                  mg[51:48] = 4'd0; mg[15:12] = 4'd0;
                  m_base = mg;
                  m_wr = nrd;
                end
          2'd2: begin
                  mg = 64'(m_wr) * 64'd32;
                  for (int b = 0; b < 8; b++) if (reg_be[b]) mg[8*b +: 8] = reg_wdata[8*b +: 8];
                  nw = int'(mg[19:5]);
                  if (nw < sz) m_wr = nw;
                end
          default: ;
        endcase
      end
      m_rd = nrd;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    check("R9 mem_req", 256'(mem_req), 256'(m_st == 1));
    if (m_st == 1) check("R9 mem_addr", 256'(mem_addr), 256'({m_base[47:12], 12'd0} + 48'(m_rd) * 48'd32));
    check("R10 cmd_valid", 256'(cmd_valid), 256'(m_st == 2));
    if (m_st == 2) check("R10 cmd_data", cmd_data, m_data);
  end

  // memory responder and command sink
  always @(negedge clk) begin
    if (!rst_n) begin
      lat = 0; mem_rvalid = 0; cmd_ready = 0;
    end else begin
      if (mem_rvalid) mem_rvalid = 0;
      else if (mem_req) begin
        lat++;
        if (lat == 2) begin
          lat = 0;
          mem_rvalid = 1;
          mem_rdata = {8{mem_addr[31:0] ^ 32'h5A5A_C3C3}};
          mem_err = (int'(mem_addr[11:5]) == err_slot);
        end
      end
      cmd_ready = (cyc % 3) != 0;
      if (cmd_valid && cmd_ready) n_hs++;
    end
  end

  task automatic wreg(input logic [1:0] sel, input logic [7:0] be, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = sel; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_be = 0;
  endtask

  task automatic rchk(input string req, input logic [1:0] sel, input logic [63:0] exp);
    @(negedge clk);
    reg_addr = sel;
    #1;
    check(req, 256'(reg_rdata), 256'(exp));
  endtask

  task automatic wait_quiet();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      reg_addr = 2'd0;
      #1;
      if (reg_rdata[31]) break;
    end
  endtask

  initial begin
    int hs0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rchk("R1 ctrl", 2'd0, 64'h8000_0000);
    rchk("R1 base", 2'd1, 64'h0);
    rchk("R1 wr", 2'd2, 64'h0);
    rchk("R1 rd", 2'd3, 64'h0);
    wreg(2'd1, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF);
    rchk("R5 base mask", 2'd1, 64'hFFF0_FFFF_FFFF_0FFF);
    rchk("R4 wr follows rd", 2'd2, 64'h0);
    wreg(2'd1, 8'h0F, 64'h0);
    rchk("R2 lane merge", 2'd1, 64'hFFF0_FFFF_0000_0000);
    wreg(2'd1, 8'hFF, 64'h0000_0000_0010_0000);
    rchk("R5 base set", 2'd1, 64'h0000_0000_0010_0000);
    wreg(2'd2, 8'hFF, 64'h1000);
    rchk("R6 wr at ring size ignored", 2'd2, 64'h0);
    wreg(2'd2, 8'hFF, 64'h5F);
    rchk("R6 wr offset bits", 2'd2, 64'h40);
    wreg(2'd3, 8'hFF, 64'h80);
    rchk("R8 rd write ignored", 2'd3, 64'h0);
    repeat (5) @(negedge clk);
    check("R9 no fetch while disabled", 256'(mem_req), 256'(0));
    rchk("R7 busy disabled", 2'd0, 64'h0);
    wreg(2'd0, 8'h01, 64'h1);
    wait_quiet();
    rchk("R10 rd advanced", 2'd3, 64'h40);
    check("R10 two commands", 256'(n_hs), 256'(2));
    rchk("R7 quiescent enabled", 2'd0, 64'h8000_0001);
    wreg(2'd1, 8'hFF, 64'h0);
    rchk("R3 base locked", 2'd1, 64'h0000_0000_0010_0000);
    rchk("R3 wr kept", 2'd2, 64'h40);
    err_slot = 2;
    hs0 = n_hs;
    wreg(2'd2, 8'hFF, 64'h80);
    wait_quiet();
    err_slot = -1;
    rchk("R11 rd past failed fetch", 2'd3, 64'h80);
    check("R11 one command sent", 256'(n_hs - hs0), 256'(1));
    wreg(2'd2, 8'h03, 64'h0FE0);
    wait_quiet();
    rchk("R12 rd at last slot", 2'd3, 64'hFE0);
    hs0 = n_hs;
    wreg(2'd2, 8'hFF, 64'h20);
    wait_quiet();
    rchk("R12 rd wrapped", 2'd3, 64'h20);
    check("R12 commands across wrap", 256'(n_hs - hs0), 256'(2));
    wreg(2'd0, 8'h01, 64'h0);
    wreg(2'd2, 8'hFF, 64'h100);
    rchk("R7 pending disabled", 2'd0, 64'h0);
    wreg(2'd1, 8'hFF, 64'h0000_0000_0010_0001);
    rchk("R4 wr forced to rd", 2'd2, 64'h20);
    rchk("R4 ring empty", 2'd0, 64'h8000_0000);
    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule